// File: doc/BRIEF.md
# Parity-Checked Switch Port Pair

This block is the datapath slice that a mesh switch places around one input-to-output path. It checks flits that carry one even-parity bit at two points: where they enter the switch and where they leave it. A failure at entry is blamed on the incoming link. A failure at exit is blamed on the switch itself. Because of these two check points, a recovery controller can tell which of the two parts is faulty.

On the upstream side, the block answers every arriving flit with ACK or NACK. Each answer travels on three identical lines. The input queue feeds the crossbar, which is outside this block, and the crossbar hands flits back to the output stage. On the downstream side, every flit that passes the exit check is sent out and kept in a local retransmission store until the next hop acknowledges it. The acknowledgements from the next hop also arrive on three lines, and a 2-of-3 vote decides them. A voted NACK makes this hop resend its own stored copies, oldest first.

A sticky flag and a saturating event counter record each kind of error. One clear input resets both flags and both counters.

Top module: `parity_port_pair`

## Requirements
- R1: An arriving flit whose parity bit differs from the XOR of its 64 data bits is dropped. It does not reach the crossbar side. `lnk_err_o` sets and `lnk_cnt_o` increments. All three `nack_up_o` lines are high in the cycle after arrival.
- R2: A flit with correct parity is queued when the 4-entry input queue has room, and all three `ack_up_o` lines are high in the cycle after arrival. When the queue is full, the flit is refused with all three NACK lines high, and no link error is recorded.
- R3: Accepted flits leave on `out_flit_o`/`out_par_o` unchanged, with the parity bit they arrived with, in arrival order. Through an idle path, a flit arriving at clock edge t is visible on the output after edge t+1.
- R4: A flit offered by the crossbar whose parity does not match is not accepted (`xo_ready_o` low) and is not sent. For every such cycle, `sw_err_o` sets and `sw_cnt_o` increments. The flit stays at the head of the queue and is offered again.
- R5: At most 4 unacknowledged flits are held. While 4 are held, no new flit is sent and the input queue fills.
- R6: A downstream ACK releases the oldest held flit only when at least 2 of the 3 `ack_dn_i` lines are high. A single high line on `ack_dn_i` or `nack_dn_i` has no effect.
- R7: A voted downstream NACK (2 of 3 lines) makes the block resend all held flits oldest first, one per cycle, starting the cycle after the NACK. New flits wait until the resend is complete. NACK takes priority over a simultaneous ACK.
- R8: Both error flags stay set until `clr_flags_i` is high for a cycle. That clear zeroes both flags and both counters. An error event in the same cycle as a clear leaves the flag set and the count at 1.
- R9: Each 8-bit error counter stops at 255.
- R10: After reset, all outputs toward neighbours are low, both flags are clear and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_flags_i | input | 1 | Clears both error flags and counters |
| in_valid_i | input | 1 | Upstream flit present |
| in_flit_i | input | 64 | Upstream flit data |
| in_par_i | input | 1 | Upstream even-parity bit |
| ack_up_o | output | 3 | Triplicated ACK to upstream |
| nack_up_o | output | 3 | Triplicated NACK to upstream |
| xbar_valid_o | output | 1 | Input queue head valid toward crossbar |
| xbar_flit_o | output | 64 | Input queue head data |
| xbar_par_o | output | 1 | Input queue head parity bit |
| xbar_ready_i | input | 1 | Crossbar takes the queue head |
| xo_valid_i | input | 1 | Crossbar offers a flit to the output stage |
| xo_flit_i | input | 64 | Offered flit data |
| xo_par_i | input | 1 | Offered flit parity bit |
| xo_ready_o | output | 1 | Output stage accepts the offered flit |
| out_valid_o | output | 1 | Flit on downstream link |
| out_flit_o | output | 64 | Downstream flit data |
| out_par_o | output | 1 | Downstream parity bit |
| ack_dn_i | input | 3 | Triplicated ACK from downstream |
| nack_dn_i | input | 3 | Triplicated NACK from downstream |
| lnk_err_o | output | 1 | Sticky link error flag |
| lnk_cnt_o | output | 8 | Saturating link error count |
| sw_err_o | output | 1 | Sticky switch error flag |
| sw_cnt_o | output | 8 | Saturating switch error count |

## Verification
The upstream ACK or NACK and the link-error flag and counter change at the edge that samples the flit. The bench therefore drives a flit at one falling edge and reads those outputs at the next falling edge. A flit that is accepted reaches the downstream register one edge later, and a resend starts one edge after the voted NACK. Because the bench never predicts the exact cycle of an output, a monitor samples on every falling edge and compares each emitted flit in order against a queue. The driver fills that queue when it sends flits and when it issues NACKs. Stalls and ignored strobes are confirmed by counting emitted flits over a fixed window. Switch-error counts are read one falling edge after the corrupted offer is withdrawn.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {OM_FWD, OM_REPLAY} om_e;
endpackage

// File: rtl/pp_vote.sv
module pp_vote #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] lines_i,
  output logic         hit_o
);
  localparam int unsigned SW = $clog2(N + 1);
  logic [SW-1:0] sum;
  always_comb begin
    sum = '0;
    for (int k = 0; k < N; k++) sum = sum + SW'(lines_i[k]);
    hit_o = (sum > SW'(N / 2));
  end
endmodule

// File: rtl/pp_fifo.sv
module pp_fifo #(
  parameter int unsigned W     = 65,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= inc(wp_q);
      if (pop_i)  rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/pp_err_track.sv
module pp_err_track #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cnt_o  <= '0;
    end else if (evt_i) begin
      flag_o <= 1'b1;
      if (clr_i)             cnt_o <= CNT_W'(1);
      else if (cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      cnt_o  <= '0;
    end
  end
endmodule

// File: rtl/pp_in_stage.sv
module pp_in_stage #(
  parameter int unsigned FLIT_W = 64,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned REP    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [FLIT_W-1:0] in_flit_i,
  input  logic              in_par_i,
  output logic [REP-1:0]    ack_up_o,
  output logic [REP-1:0]    nack_up_o,
  output logic              xbar_valid_o,
  output logic [FLIT_W-1:0] xbar_flit_o,
  output logic              xbar_par_o,
  input  logic              xbar_ready_i,
  output logic              lnk_evt_o
);
  localparam int unsigned EW = FLIT_W + 1;

  logic          par_ok, push, pop, full, empty;
  logic [EW-1:0] head;

  assign par_ok    = ((^in_flit_i) == in_par_i);
  assign lnk_evt_o = in_valid_i && !par_ok;
  assign push      = in_valid_i && par_ok && !full;
  assign pop       = xbar_valid_o && xbar_ready_i;

  // original parity bit travels with the data
  pp_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i ({in_par_i, in_flit_i}),
    .pop_i   (pop),
    .rdata_o (head),
    .full_o  (full),
    .empty_o (empty)
  );

  assign xbar_valid_o = !empty;
  assign xbar_flit_o  = head[FLIT_W-1:0];
  assign xbar_par_o   = head[FLIT_W];

  // one independent flop per response line
  for (genvar g = 0; g < REP; g++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ack_up_o[g]  <= 1'b0;
        nack_up_o[g] <= 1'b0;
      end else begin
        ack_up_o[g]  <= push;
        nack_up_o[g] <= in_valid_i && !push;
      end
    end
  end
endmodule

// File: rtl/pp_out_stage.sv
module pp_out_stage
  import pp_pkg::*;
#(
  parameter int unsigned FLIT_W = 64,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned REP    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xo_valid_i,
  input  logic [FLIT_W-1:0] xo_flit_i,
  input  logic              xo_par_i,
  output logic              xo_ready_o,
  input  logic [REP-1:0]    ack_dn_i,
  input  logic [REP-1:0]    nack_dn_i,
  output logic              out_valid_o,
  output logic [FLIT_W-1:0] out_flit_o,
  output logic              out_par_o,
  output logic              sw_evt_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = FLIT_W + 1;

  logic          ack_v, nack_v, par_ok, full, acc, pop, nack_go;
  logic [EW-1:0] rtx_q [DEPTH];
  logic [EW-1:0] out_q;
  logic [AW-1:0] hd_q, wp_q, rp_q;
  logic [CW-1:0] cnt_q, rem_q;
  om_e           mode_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  pp_vote #(.N(REP)) u_ack_vote  (.lines_i(ack_dn_i),  .hit_o(ack_v));
  pp_vote #(.N(REP)) u_nack_vote (.lines_i(nack_dn_i), .hit_o(nack_v));

  assign par_ok     = ((^xo_flit_i) == xo_par_i);
  assign full       = (cnt_q == CW'(DEPTH));
  assign xo_ready_o = (mode_q == OM_FWD) && !full && par_ok && !nack_v;
  assign acc        = xo_valid_i && xo_ready_o;
  assign sw_evt_o   = xo_valid_i && !par_ok;
  assign nack_go    = nack_v && (cnt_q != '0);
  assign pop        = ack_v && !nack_v && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (acc) rtx_q[wp_q] <= {xo_par_i, xo_flit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= OM_FWD;
      out_valid_o <= 1'b0;
      out_q       <= '0;
      hd_q        <= '0;
      wp_q        <= '0;
      rp_q        <= '0;
      cnt_q       <= '0;
      rem_q       <= '0;
    end else begin
      if (nack_go) begin
        mode_q      <= OM_REPLAY;
        rp_q        <= hd_q;
        rem_q       <= cnt_q;
        out_valid_o <= 1'b0;
      end else if (mode_q == OM_REPLAY) begin
        out_valid_o <= 1'b1;
        out_q       <= rtx_q[rp_q];
        rp_q        <= inc(rp_q);
        rem_q       <= rem_q - 1'b1;
        if (rem_q == CW'(1)) mode_q <= OM_FWD;
      end else if (acc) begin
        out_valid_o <= 1'b1;
        out_q       <= {xo_par_i, xo_flit_i};
        wp_q        <= inc(wp_q);
      end else begin
        out_valid_o <= 1'b0;
      end
      if (pop) hd_q <= inc(hd_q);
      cnt_q <= cnt_q + CW'(acc) - CW'(pop);
    end
  end

  assign out_flit_o = out_q[FLIT_W-1:0];
  assign out_par_o  = out_q[FLIT_W];
endmodule

// File: rtl/parity_port_pair.sv
module parity_port_pair #(
  parameter int unsigned FLIT_W     = 64,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned RTX_DEPTH  = 4,
  parameter int unsigned REP        = 3,
  parameter int unsigned CNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_flags_i,
  input  logic              in_valid_i,
  input  logic [FLIT_W-1:0] in_flit_i,
  input  logic              in_par_i,
  output logic [REP-1:0]    ack_up_o,
  output logic [REP-1:0]    nack_up_o,
  output logic              xbar_valid_o,
  output logic [FLIT_W-1:0] xbar_flit_o,
  output logic              xbar_par_o,
  input  logic              xbar_ready_i,
  input  logic              xo_valid_i,
  input  logic [FLIT_W-1:0] xo_flit_i,
  input  logic              xo_par_i,
  output logic              xo_ready_o,
  output logic              out_valid_o,
  output logic [FLIT_W-1:0] out_flit_o,
  output logic              out_par_o,
  input  logic [REP-1:0]    ack_dn_i,
  input  logic [REP-1:0]    nack_dn_i,
  output logic              lnk_err_o,
  output logic [CNT_W-1:0]  lnk_cnt_o,
  output logic              sw_err_o,
  output logic [CNT_W-1:0]  sw_cnt_o
);
  logic lnk_evt, sw_evt;

  pp_in_stage #(.FLIT_W(FLIT_W), .DEPTH(FIFO_DEPTH), .REP(REP)) u_in (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_flit_i    (in_flit_i),
    .in_par_i     (in_par_i),
    .ack_up_o     (ack_up_o),
    .nack_up_o    (nack_up_o),
    .xbar_valid_o (xbar_valid_o),
    .xbar_flit_o  (xbar_flit_o),
    .xbar_par_o   (xbar_par_o),
    .xbar_ready_i (xbar_ready_i),
    .lnk_evt_o    (lnk_evt)
  );

  pp_out_stage #(.FLIT_W(FLIT_W), .DEPTH(RTX_DEPTH), .REP(REP)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xo_valid_i  (xo_valid_i),
    .xo_flit_i   (xo_flit_i),
    .xo_par_i    (xo_par_i),
    .xo_ready_o  (xo_ready_o),
    .ack_dn_i    (ack_dn_i),
    .nack_dn_i   (nack_dn_i),
    .out_valid_o (out_valid_o),
    .out_flit_o  (out_flit_o),
    .out_par_o   (out_par_o),
    .sw_evt_o    (sw_evt)
  );

  pp_err_track #(.CNT_W(CNT_W)) u_lnk_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (lnk_evt),
    .clr_i  (clr_flags_i),
    .flag_o (lnk_err_o),
    .cnt_o  (lnk_cnt_o)
  );

  pp_err_track #(.CNT_W(CNT_W)) u_sw_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (sw_evt),
    .clr_i  (clr_flags_i),
    .flag_o (sw_err_o),
    .cnt_o  (sw_cnt_o)
  );
endmodule

// File: rtl/parity_port_pair_chk.sv
module parity_port_pair_chk #(
  parameter int unsigned FLIT_W = 64,
  parameter int unsigned REP    = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_flags_i,
  input logic              in_valid_i,
  input logic [FLIT_W-1:0] in_flit_i,
  input logic              in_par_i,
  input logic [REP-1:0]    nack_up_o,
  input logic              xo_valid_i,
  input logic [FLIT_W-1:0] xo_flit_i,
  input logic              xo_par_i,
  input logic              xo_ready_o,
  input logic              out_valid_o,
  input logic [FLIT_W-1:0] out_flit_o,
  input logic              out_par_o,
  input logic              lnk_err_o,
  input logic [CNT_W-1:0]  lnk_cnt_o
);
  // R1
  bad_link_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ((^in_flit_i) != in_par_i)) |=> ((nack_up_o == '1) && lnk_err_o));

  // R3
  out_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((^out_flit_o) == out_par_o));

  // R4
  bad_offer_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xo_valid_i && ((^xo_flit_i) != xo_par_i)) |-> !xo_ready_o);

  // R8
  lnk_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_err_o && !clr_flags_i) |=> lnk_err_o);

  // R9
  lnk_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lnk_cnt_o == '1) && !clr_flags_i) |=> (lnk_cnt_o == '1));
endmodule

bind parity_port_pair parity_port_pair_chk #(.FLIT_W(FLIT_W), .REP(REP), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/parity_port_pair_test.sv
`timescale 1ns/1ps
module parity_port_pair_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_flags_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] in_flit_i = '0;
  logic        in_par_i = 1'b0;
  logic [2:0]  ack_up_o, nack_up_o;
  logic        xbar_valid_o, xbar_par_o, xbar_ready_i;
  logic [63:0] xbar_flit_o;
  logic        xo_valid_i, xo_par_i, xo_ready_o;
  logic [63:0] xo_flit_i;
  logic        out_valid_o, out_par_o;
  logic [63:0] out_flit_o;
  logic [2:0]  ack_dn_i = '0, nack_dn_i = '0;
  logic        lnk_err_o, sw_err_o;
  logic [7:0]  lnk_cnt_o, sw_cnt_o;
  logic [63:0] inj_mask = '0;

  // crossbar stand-in with fault injection on the data path
  assign xo_valid_i   = xbar_valid_o;
  assign xo_flit_i    = xbar_flit_o ^ inj_mask;
  assign xo_par_i     = xbar_par_o;
  assign xbar_ready_i = xo_ready_o;

  parity_port_pair uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, n_out = 0;
  logic [64:0] exp_q[$];
  logic [64:0] ua_q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // monitor: every emitted flit must match the next expected one
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      n_out++;
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected flit", {out_par_o, out_flit_o}, '0);
      else begin
        logic [64:0] e;
        e = exp_q.pop_front();
        chk({out_par_o, out_flit_o} == e, "R3/R7", "flit order", {out_par_o, out_flit_o}, e);
      end
    end
  end

  task automatic send(input logic [63:0] d, input bit bad, input bit exp_ack, input string rq);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_flit_i  = d;
    in_par_i   = (^d) ^ bad;
    if (exp_ack) begin
      exp_q.push_back({^d, d});
      ua_q.push_back({^d, d});
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(ack_up_o == (exp_ack ? 3'b111 : 3'b000), rq, "ack_up", 65'(ack_up_o), exp_ack ? 65'd7 : 65'd0);
    chk(nack_up_o == (exp_ack ? 3'b000 : 3'b111), rq, "nack_up", 65'(nack_up_o), exp_ack ? 65'd0 : 65'd7);
  endtask

  task automatic ack(input logic [2:0] lines);
    @(negedge clk_i);
    ack_dn_i = lines;
    if ($countones(lines) >= 2 && ua_q.size() > 0) void'(ua_q.pop_front());
    @(negedge clk_i);
    ack_dn_i = '0;
  endtask

  task automatic nack(input logic [2:0] lines);
    @(negedge clk_i);
    if ($countones(lines) >= 2) foreach (ua_q[k]) exp_q.push_back(ua_q[k]);
    nack_dn_i = lines;
    @(negedge clk_i);
    nack_dn_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "R10", "watchdog expired", '0, '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] lc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(!out_valid_o && ack_up_o == 0 && nack_up_o == 0, "R10", "idle outputs",
        {out_valid_o, ack_up_o, nack_up_o}, '0);
    chk(!lnk_err_o && !sw_err_o && lnk_cnt_o == 0 && sw_cnt_o == 0, "R10", "flags",
        {lnk_err_o, sw_err_o, lnk_cnt_o, sw_cnt_o}, '0);

    // R2 R3: single flit and latency
    @(negedge clk_i);
    in_valid_i = 1'b1; in_flit_i = 64'hA5A5_0000_1234_FFFF; in_par_i = ^in_flit_i;
    exp_q.push_back({in_par_i, in_flit_i}); ua_q.push_back({in_par_i, in_flit_i});
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(ack_up_o == 3'b111, "R2", "ack after good flit", 65'(ack_up_o), 65'd7);
    chk(!out_valid_o, "R3", "not yet out", 65'(out_valid_o), 0);
    @(negedge clk_i);
    chk(out_valid_o, "R3", "out after edge t+1", 65'(out_valid_o), 1);
    ack(3'b111);

    // R1: bad link parity
    send(64'h0000_0000_0000_0001, 1'b1, 1'b0, "R1");
    chk(lnk_err_o && lnk_cnt_o == 1, "R1", "link flag/count", {lnk_err_o, lnk_cnt_o}, {1'b1, 8'd1});
    chk(!sw_err_o, "R1", "no switch flag", 65'(sw_err_o), 0);
    idle(3);

    // R3 patterns, R6 voted acks
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, "R3");
    send(64'h8000_0000_0000_0000, 1'b0, 1'b1, "R3");
    send(64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, "R3");
    idle(3);
    ack(3'b011);
    ack(3'b100);            // single line: ignored
    base = n_out;
    nack(3'b001);           // single line: ignored
    idle(4);
    chk(n_out == base, "R6", "single nack line ignored", 65'(n_out), 65'(base));
    // R7 voted nack replays the two still held, new flit waits
    nack(3'b101);
    send(64'hDEAD_BEEF_0000_0042, 1'b0, 1'b1, "R7");
    idle(6);
    chk(n_out == base + 3, "R7", "replay count + new", 65'(n_out), 65'(base + 3));
    chk(ua_q.size() == 3, "R6", "held after single ack line", 65'(ua_q.size()), 3);
    ack(3'b111); ack(3'b110); ack(3'b101);

    // R5: four held, next four wait, ninth refused
    for (int i = 0; i < 4; i++) send(64'h1000 + 64'(i), 1'b0, 1'b1, "R5");
    idle(3);
    base = n_out;
    for (int i = 4; i < 8; i++) send(64'h1000 + 64'(i), 1'b0, 1'b1, "R5");
    idle(3);
    chk(n_out == base, "R5", "stalled while full", 65'(n_out), 65'(base));
    lc = lnk_cnt_o;
    send(64'h1008, 1'b0, 1'b0, "R2");
    chk(lnk_cnt_o == lc, "R2", "full refusal not link error", 65'(lnk_cnt_o), 65'(lc));
    for (int i = 0; i < 4; i++) ack(3'b111);
    idle(4);
    chk(n_out == base + 4, "R5", "drained after acks", 65'(n_out), 65'(base + 4));
    for (int i = 0; i < 4; i++) ack(3'b111);

    // R4: corrupted offer inside the switch
    idle(2);
    inj_mask = 64'h20;
    send(64'h0F0F_0000_5555_AAAA, 1'b0, 1'b1, "R4");
    @(posedge clk_i);
    @(negedge clk_i);
    inj_mask = '0;
    chk(sw_err_o && sw_cnt_o == 1, "R4", "switch flag/count", {sw_err_o, sw_cnt_o}, {1'b1, 8'd1});
    chk(!out_valid_o, "R4", "nothing sent while corrupt", 65'(out_valid_o), 0);
    idle(3);
    ack(3'b111);

    // R8: clear, then clear with simultaneous event
    @(negedge clk_i); clr_flags_i = 1'b1;
    @(negedge clk_i); clr_flags_i = 1'b0;
    chk(!lnk_err_o && !sw_err_o && lnk_cnt_o == 0 && sw_cnt_o == 0, "R8", "cleared",
        {lnk_err_o, sw_err_o, lnk_cnt_o, sw_cnt_o}, '0);
    @(negedge clk_i);
    clr_flags_i = 1'b1; in_valid_i = 1'b1; in_flit_i = 64'h3; in_par_i = 1'b1;
    @(negedge clk_i);
    clr_flags_i = 1'b0; in_valid_i = 1'b0;
    chk(lnk_err_o && lnk_cnt_o == 1, "R8", "event beats clear", {lnk_err_o, lnk_cnt_o}, {1'b1, 8'd1});
    idle(3);
    chk(lnk_err_o, "R8", "flag sticky", 65'(lnk_err_o), 1);

    // R9: saturation
    @(negedge clk_i);
    in_valid_i = 1'b1; in_flit_i = 64'h7; in_par_i = 1'b0;
    repeat (260) @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(lnk_cnt_o == 8'hFF, "R9", "count saturates", 65'(lnk_cnt_o), 65'hFF);

    idle(5);
    chk(exp_q.size() == 0, "R3", "all expected flits seen", 65'(exp_q.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule